// File: doc/BRIEF.md
# Battery Presence Detection Sequencer

This block decides whether a battery is really attached when charging is enabled while the battery terminal sits below the short-circuit threshold. While the terminal voltage is that low, it holds off the switching stage and waits. Once the voltage climbs past the short threshold, it asks for PWM charging with the float target temporarily lowered to 4 V. It then watches a comparator flag that reports the terminal above 3.7 V, and counts millisecond ticks over a fixed window.

A real cell cannot be pushed above 3.7 V that quickly, but a bare output capacitor can. If the flag rises inside the window, the block reports a missing battery. It does this with a one-cycle status pulse, the fault code 111, a sticky no-battery flag and a request to skip the later protection-switch close test. If the window runs out without the flag, the battery counts as present and the float select returns to the programmed target.

A build parameter picks what happens after absence is found:
- The stopping variant drops the PWM request and disables the long charge timer until the supply goes away.
- The other variant keeps charging.

Removing the supply always returns the block to its initial state.

Top module: `bat_presence_seq`

## Requirements
- R1: After reset, the outputs are as follows: `bat_det`=1, `no_bat`=0, `float_4v_sel`=0, `pwm_req`=0, `stat_pulse`=0, `fault`=3'b000, `skip_sw_test`=0 and `tmr_long_dis`=0.
- R2: When charging becomes enabled (`supply_ok`=1, `chg_en_n`=0) while `bat_below_short`=1, the block does three things one clock later. It clears `bat_det`, keeps `pwm_req` low and keeps `float_4v_sel` low for as long as `bat_below_short` stays 1.
- R3: When charging becomes enabled while `bat_below_short`=0, no test is run. `bat_det` stays 1, `pwm_req` rises one clock later and `float_4v_sel` stays 0.
- R4: While waiting, the clock edge that sees `bat_below_short`=0 starts the window. From that edge on, `float_4v_sel`=1, `pwm_req`=1 and `bat_det`=0.
- R5: If `bat_above_3v7`=1 on any clock edge inside the window, the block declares the battery absent. This includes the edge that carries the last tick of the window. From that edge on, `no_bat`=1, `fault`=3'b111 and `skip_sw_test`=1, and these hold until the supply is removed. `stat_pulse` is high for exactly that one cycle.
- R6: With `STOP_ON_ABSENT`=1, absence forces `pwm_req`=0 and `tmr_long_dis`=1. With `STOP_ON_ABSENT`=0, absence leaves `pwm_req`=1 and `tmr_long_dis`=0.
- R7: If `WIN_MS` ticks pass without `bat_above_3v7`, the battery counts as present. `bat_det`=1, `float_4v_sel`=0, `pwm_req` stays 1 and `fault`=3'b000. A later `bat_above_3v7` has no effect.
- R8: `pwm_req` is 0 whenever `chg_en_n`=1. Setting `chg_en_n`=1 while waiting or inside the window abandons the test and returns the block to its initial state. The tick count is cleared, so a later window again lasts the full `WIN_MS` ticks.
- R9: `supply_ok`=0 returns the block to its initial state from any state on the next edge. That state has `bat_det`=1, `no_bat`=0, `fault`=3'b000, `skip_sw_test`=0 and `tmr_long_dis`=0.
- R10: Only `ms_tick` pulses that arrive inside the window are counted. After `WIN_MS`-1 ticks the window is still open (`float_4v_sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Input supply present |
| chg_en_n | input | 1 | Charge enable, active low |
| bat_below_short | input | 1 | Battery below short-circuit threshold |
| bat_above_3v7 | input | 1 | Battery above 3.7 V |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| bat_det | output | 1 | Battery considered present |
| no_bat | output | 1 | Battery absence found |
| float_4v_sel | output | 1 | Select temporary 4 V float target |
| pwm_req | output | 1 | Request PWM charging |
| stat_pulse | output | 1 | One-cycle status pulse on absence |
| fault | output | 3 | Fault code, 3'b111 on absence |
| skip_sw_test | output | 1 | Skip protection-switch close test |
| tmr_long_dis | output | 1 | Disable long charge timer |

## Verification
The bench checks the window edge from both sides. A voltage flag arriving together with the last tick must still count as absence; a design with an off-by-one count would report a present battery there. After one tick fewer, the window must still be open; a counter that ran a tick short would close it early. The bench also abandons a window part-way and then reopens it, to catch a tick counter that keeps its old value and shortens the second window. Finally, it runs both variants side by side, so that a design that ignored the variant parameter would show the wrong PWM request or timer disable after absence.

// File: rtl/bat_presence_seq.sv
module bat_presence_seq #(
  parameter bit STOP_ON_ABSENT = 1'b1,
  parameter int WIN_MS         = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       chg_en_n,
  input  logic       bat_below_short,
  input  logic       bat_above_3v7,
  input  logic       ms_tick,
  output logic       bat_det,
  output logic       no_bat,
  output logic       float_4v_sel,
  output logic       pwm_req,
  output logic       stat_pulse,
  output logic [2:0] fault,
  output logic       skip_sw_test,
  output logic       tmr_long_dis
);

  localparam int CNT_W = $clog2(WIN_MS + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_WIN, S_PASS, S_ABS} st_t;

  st_t              st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             stat_q;

  wire win_last = ms_tick && (cnt_q == CNT_W'(WIN_MS - 1));

  always_comb begin
    st_d = st_q;
    if (!supply_ok) st_d = S_IDLE;
    else begin
      case (st_q)
        S_IDLE: if (!chg_en_n) st_d = bat_below_short ? S_WAIT : S_PASS;
        S_WAIT: if (chg_en_n) st_d = S_IDLE;
                else if (!bat_below_short) st_d = S_WIN;
        S_WIN:  if (chg_en_n) st_d = S_IDLE;
                else if (bat_above_3v7) st_d = S_ABS;
                else if (win_last) st_d = S_PASS;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stat_q <= (st_q == S_WIN) && (st_d == S_ABS);
      if (st_q != S_WIN) cnt_q <= '0;
      else if (ms_tick)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  wire absent = (st_q == S_ABS);

  assign bat_det      = !(st_q == S_WAIT || st_q == S_WIN || absent);
  assign no_bat       = absent;
  assign float_4v_sel = (st_q == S_WIN);
  assign pwm_req      = !chg_en_n &&
                        (st_q == S_WIN || st_q == S_PASS || (absent && !STOP_ON_ABSENT));
  assign stat_pulse   = stat_q;
  assign fault        = absent ? 3'b111 : 3'b000;
  assign skip_sw_test = absent;
  assign tmr_long_dis = absent && STOP_ON_ABSENT;

endmodule

// File: rtl/bat_presence_seq_chk.sv
module bat_presence_seq_chk #(
  parameter bit STOP_ON_ABSENT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       chg_en_n,
  input logic       bat_det,
  input logic       no_bat,
  input logic       float_4v_sel,
  input logic       pwm_req,
  input logic       stat_pulse,
  input logic [2:0] fault,
  input logic       skip_sw_test,
  input logic       tmr_long_dis
);

  AST_STAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pulse |=> !stat_pulse); // R5

  AST_STAT_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pulse |-> (fault == 3'b111) && no_bat && skip_sw_test); // R5

  AST_ABSENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (no_bat && supply_ok) |=> no_bat); // R5

  AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!no_bat && fault == 3'b000 && bat_det && !skip_sw_test && !tmr_long_dis)); // R9

  AST_PWM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en_n |-> !pwm_req); // R8

  AST_FLOAT_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    float_4v_sel |-> (!bat_det && !no_bat)); // R4

  AST_VARIANT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_bat && STOP_ON_ABSENT) |-> (!pwm_req && tmr_long_dis)); // R6

endmodule

bind bat_presence_seq bat_presence_seq_chk #(.STOP_ON_ABSENT(STOP_ON_ABSENT)) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .chg_en_n(chg_en_n),
  .bat_det(bat_det), .no_bat(no_bat), .float_4v_sel(float_4v_sel),
  .pwm_req(pwm_req), .stat_pulse(stat_pulse), .fault(fault),
  .skip_sw_test(skip_sw_test), .tmr_long_dis(tmr_long_dis)
);

// File: tb/bat_presence_seq_tb_top.sv
module bat_presence_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup = 1'b0, cen_n = 1'b1, below = 1'b0, above = 1'b0, tick = 1'b0;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  logic bd, nb, fl, pw, st, sk, td;
  logic [2:0] ft;
  logic bd_k, nb_k, fl_k, pw_k, st_k, sk_k, td_k;
  logic [2:0] ft_k;

  bat_presence_seq dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(sup), .chg_en_n(cen_n),
    .bat_below_short(below), .bat_above_3v7(above), .ms_tick(tick),
    .bat_det(bd), .no_bat(nb), .float_4v_sel(fl), .pwm_req(pw),
    .stat_pulse(st), .fault(ft), .skip_sw_test(sk), .tmr_long_dis(td));

  bat_presence_seq #(.STOP_ON_ABSENT(1'b0)) dut_keep_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(sup), .chg_en_n(cen_n),
    .bat_below_short(below), .bat_above_3v7(above), .ms_tick(tick),
    .bat_det(bd_k), .no_bat(nb_k), .float_4v_sel(fl_k), .pwm_req(pw_k),
    .stat_pulse(st_k), .fault(ft_k), .skip_sw_test(sk_k), .tmr_long_dis(td_k));

  wire [9:0] obs   = {bd, nb, fl, pw, st, ft, sk, td};
  wire [9:0] obs_k = {bd_k, nb_k, fl_k, pw_k, st_k, ft_k, sk_k, td_k};

  // stimulus {supply, chg_en_n, below, above, tick} , expected {bd,nb,fl,pw,st,fault,sk,td}
  localparam logic [14:0] VEC [16] = '{
    {5'b11000, 10'b1_0_0_0_0_000_0_0},  // R1 idle, disabled
    {5'b10100, 10'b0_0_0_0_0_000_0_0},  // R2 enable below short
    {5'b10100, 10'b0_0_0_0_0_000_0_0},  // R2 still waiting
    {5'b11100, 10'b1_0_0_0_0_000_0_0},  // R8 abort from wait
    {5'b10100, 10'b0_0_0_0_0_000_0_0},  // R2
    {5'b10000, 10'b0_0_1_1_0_000_0_0},  // R4 window opens
    {5'b11000, 10'b1_0_0_0_0_000_0_0},  // R8 abort from window
    {5'b10000, 10'b1_0_0_1_0_000_0_0},  // R3 enable above short
    {5'b11000, 10'b1_0_0_0_0_000_0_0},  // R8 pwm gated
    {5'b10110, 10'b1_0_0_1_0_000_0_0},  // R7 flags ignored after pass
    {5'b00000, 10'b1_0_0_0_0_000_0_0},  // R9 supply removed
    {5'b10100, 10'b0_0_0_0_0_000_0_0},  // R2
    {5'b10000, 10'b0_0_1_1_0_000_0_0},  // R4
    {5'b10010, 10'b0_1_0_0_1_111_1_1},  // R5 absent found
    {5'b10000, 10'b0_1_0_0_0_111_1_1},  // R5 pulse ends, sticky
    {5'b00000, 10'b1_0_0_0_0_000_0_0}   // R9 clears
  };

  task automatic step(input logic [4:0] s);
    @(negedge clk);
    {sup, cen_n, below, above, tick} = s;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic open_window();
    step(5'b00000);
    step(5'b10100);
    step(5'b10000);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", obs, 10'b1_0_0_0_0_000_0_0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][14:10]);
      check($sformatf("vector %0d (R1 R2 R3 R4 R5 R8 R9)", i), obs, VEC[i][9:0]);
    end

    // R10 / R7: window of exactly WIN_MS ticks
    open_window();
    for (int i = 0; i < 31; i++) step(5'b10001);
    check("R10 window open after 31 ticks", obs, 10'b0_0_1_1_0_000_0_0);
    step(5'b10001);
    check("R7 present after 32 ticks", obs, 10'b1_0_0_1_0_000_0_0);
    step(5'b10010);
    check("R7 late flag ignored", obs, 10'b1_0_0_1_0_000_0_0);

    // R5 / R6: flag on the last tick still counts as absence
    open_window();
    for (int i = 0; i < 31; i++) step(5'b10001);
    step(5'b10011);
    check("R5 absent on last tick", obs, 10'b0_1_0_0_1_111_1_1);
    check("R6 keep variant continues", obs_k, 10'b0_1_0_1_1_111_1_0);
    step(5'b10000);
    check("R5 single pulse", obs, 10'b0_1_0_0_0_111_1_1);
    check("R6 keep variant pulse ends", obs_k, 10'b0_1_0_1_0_111_1_0);
    step(5'b11000);
    check("R8 keep variant gated", obs_k, 10'b0_1_0_0_0_111_1_0);

    // R8: abandoned window clears its tick count
    open_window();
    for (int i = 0; i < 20; i++) step(5'b10001);
    step(5'b11000);
    check("R8 abort mid window", obs, 10'b1_0_0_0_0_000_0_0);
    step(5'b10100);
    step(5'b10000);
    for (int i = 0; i < 31; i++) step(5'b10001);
    check("R8 count restarted", obs, 10'b0_0_1_1_0_000_0_0);
    step(5'b10001);
    check("R7 full second window", obs, 10'b1_0_0_1_0_000_0_0);

    // R9 from pass state
    step(5'b00000);
    check("R9 supply removal from pass", obs, 10'b1_0_0_0_0_000_0_0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule